// File: doc/BRIEF.md
# Chunked Packet Buffer with Linked Free Pool

This block keeps packets of varying length in a single data memory that is cut into equal chunks of `CHUNK_LINES` lines. A packet takes as many chunks as its length needs. The chunks of one packet are chained through a next-chunk table, and every chunk that no packet holds sits in a show-ahead FIFO of chunk numbers. The write side always shows the chunk that the next packet will start in. The user records that number as the packet's handle, then streams lines in and marks the last one.

To read a packet, the user loads it by its handle, waits for the acknowledge and then pulls one line per strobe. Each chunk the reader leaves behind goes back to the free pool straight away. The chunk holding the final lines stays allocated until a release is issued. A release can also drop a packet that was never read: it follows the chain and returns one chunk per cycle. The data memory, the link table and the free FIFO are plain inferred arrays. `NUM_CHUNKS` and `CHUNK_LINES` must be powers of two, and `CHUNK_LINES` must be at least 2. Any sideband bits per line are simply part of `LINE_W`.

Top module: `pktbuf_top`

## Requirements
- R1: After reset the free pool holds every chunk number once, in ascending order from 0. `nextFirstChunk` is 0, `freeEmpty` and `freeAlmostEmpty` are low, `reqAck` is low.
- R2: Whenever the pool is not empty, `nextFirstChunk` equals the oldest chunk in the free pool. It changes only when a chunk is taken from the pool.
- R3: Each accepted write strobe stores `wrData` as one line. The first line of a packet, and each line after every `CHUNK_LINES` lines of the same packet, goes to the chunk taken from the head of the pool. Any other line goes to the next position of the current chunk. A strobe with `wrLast` high ends the packet, and `wrLast` is not stored.
- R4: `freeEmpty` is high exactly when the pool holds no chunk. A write strobe that needs a new chunk while the pool is empty is ignored.
- R5: `freeAlmostEmpty` is high exactly when the pool holds `AEMPTY_LVL` chunks or fewer.
- R6: An accepted load request (`loadReq` with `chunkIn` as the handle) makes `reqAck` high for one cycle on the next clock.
- R7: After a load, each read strobe returns the next line of the packet on `rdData` one clock later, all `LINE_W` bits as written. Between accepted strobes, `rdData` holds its value.
- R8: A read strobe that moves from a finished chunk into the packet's next chunk appends the finished chunk to the tail of the pool. A read strobe issued after all lines of the packet's final chunk are consumed is ignored.
- R9: An accepted release returns the packet's remaining chunks to the pool tail, one per cycle in chain order, and `reqAck` rises on the clock after the last one. After a load, the release starts at the reader's current chunk and `chunkIn` is ignored. Otherwise the release starts at `chunkIn`.
- R10: While a release is being walked, load and release requests are ignored. If load and release are requested in the same cycle, only the load is taken.
- R11: The pool never holds more than `NUM_CHUNKS` chunks, and a chunk is never pushed when the pool is full.
- R12: Taking a chunk for a write and returning a chunk in the same cycle loses neither chunk. The pool count changes by exactly the net number of pushes and pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nextFirstChunk | output | log2(NUM_CHUNKS) | Chunk the next packet will start in |
| freeAlmostEmpty | output | 1 | Pool holds AEMPTY_LVL chunks or fewer |
| freeEmpty | output | 1 | Pool holds no chunk |
| wrStrobe | input | 1 | Store one line |
| wrData | input | LINE_W | Line to store |
| wrLast | input | 1 | This line ends the packet |
| chunkIn | input | log2(NUM_CHUNKS) | Packet handle for load or release |
| loadReq | input | 1 | Start reading the packet at chunkIn |
| releaseReq | input | 1 | Return the packet's chunks to the pool |
| reqAck | output | 1 | One-cycle acknowledge of a load or a finished release |
| rdStrobe | input | 1 | Fetch the next line of the loaded packet |
| rdData | output | LINE_W | Line fetched by the previous strobe |

## Verification
On every cycle, the assertions check the pool bookkeeping: the bound on the pool count, that no push happens into a full pool, that the count tracks pops, that the head stays steady while nothing is popped, that empty implies almost-empty, and the acknowledge that follows a load. The bench scenarios are needed for the rest. They show that data comes back in the right order across chunk hops, that chunks return to the pool at the right moment and in the right order, that a release resumes from the reader's chunk, that requests are ignored while a walk is busy, and that writes are refused once the pool is drained.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;
  // Strobes from the control to the datapath, one per storage action
  typedef struct packed {
    logic popFree;   // take the head chunk of the free pool
    logic pushFree;  // append pushChunk to the pool tail
    logic dataWr;    // store one data line
    logic dataRd;    // fetch one data line into rdData
    logic linkNew;   // mark a freshly taken chunk as chain end
    logic linkPrev;  // chain the previous chunk to a new one
  } bufStrobes_t;
endpackage

// File: rtl/pktbuf_dp.sv
module pktbuf_dp
  import pktbuf_pkg::*;
#(
  parameter int NUM_CHUNKS  = 64,
  parameter int CHUNK_LINES = 8,
  parameter int LINE_W      = 32,
  parameter int AEMPTY_LVL  = 2,
  localparam int CW = $clog2(NUM_CHUNKS),
  localparam int OW = $clog2(CHUNK_LINES),
  localparam int AW = CW + OW
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobes_t       stb,
  input  logic [CW-1:0]     pushChunk,
  input  logic [CW-1:0]     linkNewIdx,
  input  logic [CW-1:0]     linkPrevIdx,
  input  logic [CW-1:0]     linkPrevNext,
  input  logic [AW-1:0]     dataWrAddr,
  input  logic [LINE_W-1:0] dataWrData,
  input  logic [AW-1:0]     dataRdAddr,
  input  logic [CW-1:0]     linkRdAIdx,
  input  logic [CW-1:0]     linkRdBIdx,
  output logic [CW-1:0]     freeHead,
  output logic [CW:0]       freeCount,
  output logic              freeEmpty,
  output logic              freeAEmpty,
  output logic [CW-1:0]     linkANext,
  output logic              linkALast,
  output logic [CW-1:0]     linkBNext,
  output logic              linkBLast,
  output logic [LINE_W-1:0] rdData
);
  localparam int LINES = NUM_CHUNKS * CHUNK_LINES;

  // Free pool: circular FIFO of chunk numbers, show-ahead head
  logic [CW-1:0] fifoMem [NUM_CHUNKS];
  logic [CW-1:0] headPtr, tailPtr;

  function automatic logic [CW-1:0] bumpPtr(input logic [CW-1:0] p);
    return (p == CW'(NUM_CHUNKS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      freeCount <= (CW+1)'(NUM_CHUNKS);
      for (int i = 0; i < NUM_CHUNKS; i++) fifoMem[i] <= CW'(i);
    end else begin
      if (stb.pushFree) begin
        fifoMem[tailPtr] <= pushChunk;
        tailPtr          <= bumpPtr(tailPtr);
      end
      if (stb.popFree) headPtr <= bumpPtr(headPtr);
      case ({stb.pushFree, stb.popFree})
        2'b10:   freeCount <= freeCount + 1'b1;
        2'b01:   freeCount <= freeCount - 1'b1;
        default: freeCount <= freeCount;
      endcase
    end
  end

  assign freeHead   = fifoMem[headPtr];
  assign freeEmpty  = (freeCount == '0);
  assign freeAEmpty = (freeCount <= (CW+1)'(AEMPTY_LVL));

  // Link table: successor and chain-end flag per chunk
  logic [CW-1:0]         linkNext [NUM_CHUNKS];
  logic [NUM_CHUNKS-1:0] linkLast;

  always_ff @(posedge clk) begin
    if (stb.linkNew) linkLast[linkNewIdx] <= 1'b1;
    if (stb.linkPrev) begin
      linkLast[linkPrevIdx] <= 1'b0;
      linkNext[linkPrevIdx] <= linkPrevNext;
    end
  end

  assign linkANext = linkNext[linkRdAIdx];
  assign linkALast = linkLast[linkRdAIdx];
  assign linkBNext = linkNext[linkRdBIdx];
  assign linkBLast = linkLast[linkRdBIdx];

  // Data memory, one registered read port
  logic [LINE_W-1:0] dataMem [LINES];

  always_ff @(posedge clk) begin
    if (stb.dataWr) dataMem[dataWrAddr] <= dataWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (stb.dataRd) rdData <= dataMem[dataRdAddr];
  end
endmodule

// File: rtl/pktbuf_ctrl.sv
module pktbuf_ctrl
  import pktbuf_pkg::*;
#(
  parameter int NUM_CHUNKS  = 64,
  parameter int CHUNK_LINES = 8,
  localparam int CW = $clog2(NUM_CHUNKS),
  localparam int OW = $clog2(CHUNK_LINES),
  localparam int AW = CW + OW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrStrobe,
  input  logic          wrLast,
  input  logic [CW-1:0] chunkIn,
  input  logic          loadReq,
  input  logic          releaseReq,
  input  logic          rdStrobe,
  input  logic [CW-1:0] freeHead,
  input  logic          freeEmpty,
  input  logic [CW-1:0] linkANext,
  input  logic          linkALast,
  input  logic [CW-1:0] linkBNext,
  input  logic          linkBLast,
  output bufStrobes_t   stb,
  output logic [CW-1:0] pushChunk,
  output logic [CW-1:0] linkNewIdx,
  output logic [CW-1:0] linkPrevIdx,
  output logic [CW-1:0] linkPrevNext,
  output logic [AW-1:0] dataWrAddr,
  output logic [AW-1:0] dataRdAddr,
  output logic [CW-1:0] linkRdAIdx,
  output logic [CW-1:0] linkRdBIdx,
  output logic          reqAck,
  output logic          relBusy
);
  // Write position
  logic [CW-1:0] wrChunk;
  logic [OW-1:0] wrOff;
  logic          wrOpen;
  // Read position; rdOff == CHUNK_LINES means the chunk is used up
  logic [CW-1:0] rdChunk;
  logic [OW:0]   rdOff;
  logic          rdActive;
  // Release walk
  logic [CW-1:0] walkChunk;

  logic          needChunk, wrGo, loadGo, relGo, rdEdge, rdGo, rdHop, walkDone;
  logic [CW-1:0] wrTarget, rdSrcChunk;
  logic [OW-1:0] rdSrcOff;

  always_comb begin
    needChunk = (wrOff == '0);
    wrGo      = wrStrobe && !(needChunk && freeEmpty);
    wrTarget  = needChunk ? freeHead : wrChunk;

    loadGo    = loadReq && !relBusy;
    relGo     = releaseReq && !loadReq && !relBusy;
    walkDone  = relBusy && linkBLast;

    rdEdge     = (rdOff == (OW+1)'(CHUNK_LINES));
    rdGo       = rdStrobe && rdActive && !loadGo && !relGo && !(rdEdge && linkALast);
    rdHop      = rdGo && rdEdge;
    rdSrcChunk = rdHop ? linkANext : rdChunk;
    rdSrcOff   = rdHop ? '0 : rdOff[OW-1:0];

    stb.popFree  = wrGo && needChunk;
    stb.linkNew  = wrGo && needChunk;
    stb.linkPrev = wrGo && needChunk && wrOpen;
    stb.dataWr   = wrGo;
    stb.dataRd   = rdGo;
    stb.pushFree = rdHop || relBusy;

    pushChunk    = rdHop ? rdChunk : walkChunk;
    linkNewIdx   = freeHead;
    linkPrevIdx  = wrChunk;
    linkPrevNext = freeHead;
    dataWrAddr   = {wrTarget, wrOff};
    dataRdAddr   = {rdSrcChunk, rdSrcOff};
    linkRdAIdx   = rdChunk;
    linkRdBIdx   = walkChunk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrChunk <= '0;
      wrOff   <= '0;
      wrOpen  <= 1'b0;
    end else if (wrGo) begin
      wrChunk <= wrTarget;
      wrOpen  <= !wrLast;
      wrOff   <= wrLast ? '0 : wrOff + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdChunk  <= '0;
      rdOff    <= '0;
      rdActive <= 1'b0;
    end else if (loadGo) begin
      rdChunk  <= chunkIn;
      rdOff    <= '0;
      rdActive <= 1'b1;
    end else if (relGo) begin
      rdActive <= 1'b0;
    end else if (rdGo) begin
      rdChunk <= rdSrcChunk;
      rdOff   <= rdHop ? (OW+1)'(1) : rdOff + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relBusy   <= 1'b0;
      walkChunk <= '0;
      reqAck    <= 1'b0;
    end else begin
      reqAck <= loadGo || walkDone;
      if (relGo) begin
        relBusy   <= 1'b1;
        walkChunk <= rdActive ? rdChunk : chunkIn;
      end else if (relBusy) begin
        if (linkBLast) relBusy   <= 1'b0;
        else           walkChunk <= linkBNext;
      end
    end
  end
endmodule

// File: rtl/pktbuf_top.sv
module pktbuf_top
  import pktbuf_pkg::*;
#(
  parameter int NUM_CHUNKS  = 64,
  parameter int CHUNK_LINES = 8,
  parameter int LINE_W      = 32,
  parameter int AEMPTY_LVL  = 2,
  localparam int CW = $clog2(NUM_CHUNKS),
  localparam int AW = CW + $clog2(CHUNK_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [CW-1:0]     nextFirstChunk,
  output logic              freeAlmostEmpty,
  output logic              freeEmpty,
  input  logic              wrStrobe,
  input  logic [LINE_W-1:0] wrData,
  input  logic              wrLast,
  input  logic [CW-1:0]     chunkIn,
  input  logic              loadReq,
  input  logic              releaseReq,
  output logic              reqAck,
  input  logic              rdStrobe,
  output logic [LINE_W-1:0] rdData
);
  bufStrobes_t   stb;
  logic [CW-1:0] pushChunk, linkNewIdx, linkPrevIdx, linkPrevNext;
  logic [CW-1:0] linkRdAIdx, linkRdBIdx, linkANext, linkBNext;
  logic          linkALast, linkBLast, relBusy;
  logic [AW-1:0] dataWrAddr, dataRdAddr;
  logic [CW:0]   freeCount;

  pktbuf_ctrl #(.NUM_CHUNKS(NUM_CHUNKS), .CHUNK_LINES(CHUNK_LINES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrLast(wrLast),
    .chunkIn(chunkIn), .loadReq(loadReq), .releaseReq(releaseReq),
    .rdStrobe(rdStrobe), .freeHead(nextFirstChunk), .freeEmpty(freeEmpty),
    .linkANext(linkANext), .linkALast(linkALast),
    .linkBNext(linkBNext), .linkBLast(linkBLast),
    .stb(stb), .pushChunk(pushChunk), .linkNewIdx(linkNewIdx),
    .linkPrevIdx(linkPrevIdx), .linkPrevNext(linkPrevNext),
    .dataWrAddr(dataWrAddr), .dataRdAddr(dataRdAddr),
    .linkRdAIdx(linkRdAIdx), .linkRdBIdx(linkRdBIdx),
    .reqAck(reqAck), .relBusy(relBusy)
  );

  pktbuf_dp #(
    .NUM_CHUNKS(NUM_CHUNKS), .CHUNK_LINES(CHUNK_LINES),
    .LINE_W(LINE_W), .AEMPTY_LVL(AEMPTY_LVL)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .pushChunk(pushChunk),
    .linkNewIdx(linkNewIdx), .linkPrevIdx(linkPrevIdx), .linkPrevNext(linkPrevNext),
    .dataWrAddr(dataWrAddr), .dataWrData(wrData), .dataRdAddr(dataRdAddr),
    .linkRdAIdx(linkRdAIdx), .linkRdBIdx(linkRdBIdx),
    .freeHead(nextFirstChunk), .freeCount(freeCount), .freeEmpty(freeEmpty),
    .freeAEmpty(freeAlmostEmpty), .linkANext(linkANext), .linkALast(linkALast),
    .linkBNext(linkBNext), .linkBLast(linkBLast), .rdData(rdData)
  );
endmodule

// File: rtl/pktbuf_chk.sv
module pktbuf_chk
  import pktbuf_pkg::*;
#(
  parameter int NUM_CHUNKS = 64,
  localparam int CW = $clog2(NUM_CHUNKS)
) (
  input logic          clk,
  input logic          rstN,
  input logic          freeEmpty,
  input logic          freeAlmostEmpty,
  input logic [CW-1:0] nextFirstChunk,
  input logic          loadReq,
  input logic          reqAck,
  input logic          relBusy,
  input bufStrobes_t   stb,
  input logic [CW:0]   freeCount
);
  // R5
  empty_implies_aempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeEmpty |-> freeAlmostEmpty);

  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeCount <= (CW+1)'(NUM_CHUNKS));

  // R11
  push_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.pushFree |-> (freeCount < (CW+1)'(NUM_CHUNKS)));

  // R12
  count_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.popFree && !stb.pushFree) |=> (freeCount == $past(freeCount) - 1'b1));

  // R2
  head_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.popFree && !freeEmpty) |=> $stable(nextFirstChunk));

  // R6
  load_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && !relBusy) |=> reqAck);
endmodule

bind pktbuf_top pktbuf_chk #(.NUM_CHUNKS(NUM_CHUNKS)) chk_i (
  .clk(clk), .rstN(rstN), .freeEmpty(freeEmpty), .freeAlmostEmpty(freeAlmostEmpty),
  .nextFirstChunk(nextFirstChunk), .loadReq(loadReq), .reqAck(reqAck),
  .relBusy(relBusy), .stb(stb), .freeCount(freeCount)
);

// File: tb/pktbuf_top_tb_top.sv
module pktbuf_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUMC = 64;
  localparam int L    = 8;
  localparam int W    = 32;
  localparam int LVL  = 2;
  localparam int CW   = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b1;
  logic [CW-1:0] nextFirstChunk, chunkIn;
  logic          freeAlmostEmpty, freeEmpty, wrStrobe, wrLast;
  logic          loadReq, releaseReq, reqAck, rdStrobe;
  logic [W-1:0]  wrData, rdData;

  pktbuf_top dut_i (
    .clk(clk), .rstN(rstN), .nextFirstChunk(nextFirstChunk),
    .freeAlmostEmpty(freeAlmostEmpty), .freeEmpty(freeEmpty),
    .wrStrobe(wrStrobe), .wrData(wrData), .wrLast(wrLast), .chunkIn(chunkIn),
    .loadReq(loadReq), .releaseReq(releaseReq), .reqAck(reqAck),
    .rdStrobe(rdStrobe), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vecs = 0;
  int errs = 0;

  // Behavioural reference: pool as a queue, packets as lists of chunks
  int           freeQ[$];
  logic [W-1:0] memM [int];
  int           pktCh [NUMC][$];
  int           wOff = 0, wCur = 0, wFirst = 0;
  bit           wOpen = 0;
  bit           rActive = 0;
  int           rList[$];
  int           rIdx = 0, rOff = 0;
  bit           walking = 0;
  int           walkList[$];
  bit           expAck = 0;
  bit           rdValid = 0;
  logic [W-1:0] expRd = '0;

  task automatic modelEdge();
    bit busy0 = walking;
    int cnt0  = freeQ.size();
    bit loadGo, relGo;
    int c;
    expAck = 0;
    // R3 / R4: write side
    if (wrStrobe && !(wOff == 0 && cnt0 == 0)) begin
      if (wOff == 0) begin
        c = freeQ.pop_front();
        if (!wOpen) begin wFirst = c; pktCh[c].delete(); end
        pktCh[wFirst].push_back(c);
        wCur = c;
      end
      memM[wCur*L + wOff] = wrData;
      wOpen = !wrLast;
      wOff  = wrLast ? 0 : (wOff + 1) % L;
    end
    // R9: walk returns one chunk per cycle
    if (busy0) begin
      c = walkList.pop_front();
      freeQ.push_back(c);
      if (walkList.size() == 0) begin walking = 0; expAck = 1; end
    end
    // R10: requests ignored while busy, load wins
    loadGo = loadReq && !busy0;
    relGo  = releaseReq && !loadReq && !busy0;
    if (loadGo) begin
      rActive = 1; rList = pktCh[int'(chunkIn)]; rIdx = 0; rOff = 0; expAck = 1;
    end else if (relGo) begin
      walkList.delete();
      if (rActive) for (int i = rIdx; i < rList.size(); i++) walkList.push_back(rList[i]);
      else walkList = pktCh[int'(chunkIn)];
      rActive = 0; walking = 1;
    end else if (rdStrobe && rActive) begin
      // R8: hop frees the finished chunk, final chunk stays
      if (rOff == L && rIdx < rList.size() - 1) begin
        freeQ.push_back(rList[rIdx]); rIdx++; rOff = 0;
      end
      if (rOff < L) begin
        expRd = memM[rList[rIdx]*L + rOff]; rdValid = 1; rOff++;
      end
    end
  endtask

  task automatic chk(bit ok, string tag, longint act, longint exp);
    if (!ok) begin
      errs++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    vecs++;
    chk(reqAck == expAck, "R6/R9 reqAck", reqAck, expAck);
    chk(freeEmpty == (freeQ.size() == 0), "R4 freeEmpty", freeEmpty, freeQ.size() == 0);
    chk(freeAlmostEmpty == (freeQ.size() <= LVL), "R5 freeAlmostEmpty",
        freeAlmostEmpty, freeQ.size() <= LVL);
    if (freeQ.size() > 0)
      chk(int'(nextFirstChunk) == freeQ[0], "R2/R8/R12 nextFirstChunk", nextFirstChunk, freeQ[0]);
    if (rdValid) chk(rdData == expRd, "R7/R3 rdData", rdData, expRd);
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compare();
  endtask

  task automatic quiet();
    wrStrobe = 0; wrLast = 0; loadReq = 0; releaseReq = 0; rdStrobe = 0;
  endtask

  task automatic writePkt(int n, int tagv, output int first);
    first = int'(nextFirstChunk);
    for (int i = 0; i < n; i++) begin
      wrStrobe = 1; wrLast = (i == n - 1);
      wrData = W'(32'h5A000000 ^ (tagv << 12) ^ (i * 32'h00010003));
      step();
    end
    quiet();
  endtask

  task automatic loadPkt(int first);
    chunkIn = CW'(first); loadReq = 1; step(); quiet();
  endtask

  task automatic readLines(int n);
    for (int i = 0; i < n; i++) begin rdStrobe = 1; step(); end
    quiet();
  endtask

  task automatic releasePkt(int first);
    chunkIn = CW'(first); releaseReq = 1; step(); quiet();
    while (walking) step();
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int pA, pB, pC, pD, pF, pG, n;
    quiet(); chunkIn = '0; wrData = '0;
    for (int i = 0; i < NUMC; i++) freeQ.push_back(i);
    #1 rstN = 0;
    repeat (3) @(negedge clk);
    // R1: reset state, pool ascending from 0
    compare();
    chk(nextFirstChunk == 0, "R1 head after reset", nextFirstChunk, 0);
    chk(!reqAck && !freeEmpty && !freeAlmostEmpty, "R1 flags after reset", reqAck, 0);
    rstN = 1;
    step(); step();

    // R3: packets of several lengths, one spanning three chunks
    writePkt(3, 1, pA);
    writePkt(20, 2, pB);
    writePkt(8, 3, pC);
    writePkt(16, 4, pD);
    chk(pA == 0 && pB == 1 && pC == 4 && pD == 5, "R1/R2 handles", pD, 5);

    // R7/R8: read B across two hops, then R9 release with a bogus handle
    loadPkt(pB);
    readLines(20);
    releasePkt(33);

    // R9: release A without reading it
    releasePkt(pA);

    // R8: read C, extra strobes at the end of the final chunk are ignored
    loadPkt(pC);
    readLines(10);
    releasePkt(pC);

    // R12/R10: write F while D is walked; a load during the walk is ignored
    pF = int'(nextFirstChunk);
    chunkIn = CW'(pD); releaseReq = 1; step(); quiet();
    for (int i = 0; i < 5; i++) begin
      wrStrobe = 1; wrLast = (i == 4); wrData = W'(32'hC0DE0000 + i);
      loadReq = (i == 0); chunkIn = CW'(pF);
      step();
    end
    quiet(); step();

    // R10: load and release together, load wins; release then follows the read
    chunkIn = CW'(pF); loadReq = 1; releaseReq = 1; step(); quiet();
    readLines(5);
    releasePkt(pF);

    // R4/R5: drain the pool with one packet, then a refused write
    n = freeQ.size() * L;
    writePkt(n, 7, pG);
    wrStrobe = 1; wrLast = 1; wrData = '1; step(); quiet();
    chk(freeEmpty == 1, "R4 pool drained", freeEmpty, 1);
    loadPkt(pG);
    readLines(L + 2);
    releasePkt(pG);
    chk(freeQ.size() == NUMC && !freeAlmostEmpty, "R11 pool refilled", freeAlmostEmpty, 0);
    repeat (3) step();

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule